// File: doc/BRIEF.md
# Modem Status Change Detector

This block produces the modem status byte of a 16550-style serial port. Four active-low modem lines (clear-to-send, data-set-ready, ring indicator, carrier detect) enter through a synchronizer. The block shows their current levels as active-high bits. It also records every relevant change of those levels in four sticky flags. A processor read of the byte clears the flags. Any flag that is set, together with an enable, raises an interrupt request.

In loopback the external lines are ignored. The four modem-control outputs of the port (request-to-send, terminal-ready and two auxiliary outputs) stand in for the lines, and changes are detected on those looped-back values. Two small state machines control the flow. A priming machine (states `PRIME_WAIT` and `PRIME_RUN`) suppresses change detection until the synchronizer holds real pin values. `PRIME_WAIT` moves to `PRIME_RUN` after `SYNC_STAGES + 1` clock edges. Each change flag runs its own machine (states `FLAG_CLEAR` and `FLAG_SET`). `FLAG_CLEAR` moves to `FLAG_SET` on a detected change. `FLAG_SET` moves back to `FLAG_CLEAR` on a read in a cycle with no new change.

Top module: `modem_status_reg`

## Requirements
- R1: Outside loopback, `stat_q[4+i]` equals the inverse of `pin_n[i]` (i=0 clear-to-send, 1 data-set-ready, 2 ring, 3 carrier detect), visible after two clock edges of synchronization.
- R2: In loopback (`loop_en`=1), `stat_q[4+i]` equals `loop_ctl[i]` (0 request-to-send, 1 terminal-ready, 2 first auxiliary output, 3 second auxiliary output) and `pin_n` has no effect on `stat_q`.
- R3: `stat_q[0]`, `stat_q[1]` and `stat_q[3]` set on either edge of the level of bit 4, 5 and 7 respectively.
- R4: `stat_q[2]` sets only when the ring level (`stat_q[6]`) falls from 1 to 0, i.e. when the ring pin returns from 0 to 1, or when `loop_ctl[2]` falls in loopback; a rising ring level leaves it unchanged.
- R5: A one-cycle `stat_rd` pulse clears `stat_q[3:0]` on the next clock edge when no change is detected in that cycle.
- R6: A change detected on the same edge as a read leaves its flag set.
- R7: A set flag stays set until a read.
- R8: `stat_irq` is high exactly when `stat_irq_en` is high and at least one of `stat_q[3:0]` is set.
- R9: Reset clears all flags and the interrupt. For `SYNC_STAGES + 1` edges after reset no change is recorded, so a level held through reset sets no flag.
- R10: Entering or leaving loopback counts as a change for every level it alters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 4 | Active-low modem lines: 0 clear-to-send, 1 data-set-ready, 2 ring, 3 carrier detect |
| loop_en | input | 1 | Loopback enable |
| loop_ctl | input | 4 | Modem-control bits used in loopback: 0 request-to-send, 1 terminal-ready, 2 aux 1, 3 aux 2 |
| stat_rd | input | 1 | One-cycle read strobe of the status byte |
| stat_irq_en | input | 1 | Modem-status interrupt enable |
| stat_q | output | 8 | Status byte: [7:4] levels, [3:0] change flags |
| stat_irq | output | 1 | Modem-status interrupt request |

## Verification
The change assertions take `loop_ctl` and `loop_en` to be synchronous to `clk`. They judge edges only in loopback, where a change reaches the detector without synchronizer delay, and only after the priming window, which the checker measures with its own counter. The bench drives every input on the falling edge. It holds each vector for four edges, so that changes on the external lines have passed through the synchronizer before anything is sampled.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int NUM_LINES = 4;
    localparam int RING_IDX  = 2;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_t;

    typedef enum logic {
        PRIME_WAIT = 1'b0,
        PRIME_RUN  = 1'b1
    } prime_state_t;

    typedef enum logic {
        EDGE_BOTH = 1'b0,
        EDGE_FALL = 1'b1
    } edge_mode_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int   STAGES    = 2,
    parameter int   WIDTH     = 4,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= {WIDTH{RESET_VAL}};
                end else if (s == 0) begin
                    chain[s] <= d_in;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/msr_level_select.sv
module msr_level_select #(
    parameter int WIDTH = 4
) (
    input  logic             loop_en,
    input  logic [WIDTH-1:0] sync_n,
    input  logic [WIDTH-1:0] ctl,
    output logic [WIDTH-1:0] level
);
    always_comb begin
        if (loop_en) begin
            level = ctl;
        end else begin
            level = ~sync_n;
        end
    end
endmodule

// File: rtl/msr_prime_fsm.sv
module msr_prime_fsm
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic detect_en
);
    localparam int CNT_W = $clog2(SYNC_STAGES + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_STAGES);

    prime_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PRIME_WAIT: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = PRIME_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PRIME_RUN: begin
                state_d = PRIME_RUN;
            end
            default: state_d = PRIME_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PRIME_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            PRIME_WAIT: detect_en = 1'b0;
            PRIME_RUN:  detect_en = 1'b1;
            default:    detect_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/msr_change_flag.sv
module msr_change_flag
    import msr_pkg::*;
#(
    parameter edge_mode_t EDGE_MODE = EDGE_BOTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic detect_en,
    input  logic level,
    input  logic rd,
    output logic flag
);
    flag_state_t state_q, state_d;
    logic        prev_q;
    logic        change;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level;
        end
    end

    generate
        if (EDGE_MODE == EDGE_FALL) begin : g_fall
            assign change = detect_en & prev_q & ~level;
        end else begin : g_both
            assign change = detect_en & (prev_q ^ level);
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: begin
                if (change) state_d = FLAG_SET;
            end
            FLAG_SET: begin
                if (rd && !change) state_d = FLAG_CLEAR;
            end
            default: state_d = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            FLAG_CLEAR: flag = 1'b0;
            FLAG_SET:   flag = 1'b1;
            default:    flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_n,
    input  logic                 loop_en,
    input  logic [NUM_LINES-1:0] loop_ctl,
    input  logic                 stat_rd,
    input  logic                 stat_irq_en,
    output logic [2*NUM_LINES-1:0] stat_q,
    output logic                 stat_irq
);
    logic [NUM_LINES-1:0] pins_sync_n;
    logic [NUM_LINES-1:0] level;
    logic [NUM_LINES-1:0] flags;
    logic                 detect_en;

    msr_sync #(
        .STAGES   (SYNC_STAGES),
        .WIDTH    (NUM_LINES),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (pin_n),
        .d_out(pins_sync_n)
    );

    msr_level_select #(
        .WIDTH(NUM_LINES)
    ) u_select (
        .loop_en(loop_en),
        .sync_n (pins_sync_n),
        .ctl    (loop_ctl),
        .level  (level)
    );

    msr_prime_fsm #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_prime (
        .clk      (clk),
        .rst_n    (rst_n),
        .detect_en(detect_en)
    );

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            localparam edge_mode_t MODE = (i == RING_IDX) ? EDGE_FALL : EDGE_BOTH;
            msr_change_flag #(
                .EDGE_MODE(MODE)
            ) u_flag (
                .clk      (clk),
                .rst_n    (rst_n),
                .detect_en(detect_en),
                .level    (level[i]),
                .rd       (stat_rd),
                .flag     (flags[i])
            );
        end
    endgenerate

    assign stat_q   = {level, flags};
    assign stat_irq = stat_irq_en & (|flags);
endmodule

// File: rtl/msr_checker.sv
module msr_checker #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       loop_en,
    input logic [3:0] loop_ctl,
    input logic       stat_rd,
    input logic       stat_irq_en,
    input logic [7:0] stat_q,
    input logic       stat_irq
);
    localparam int CW = $clog2(SYNC_STAGES + 3);
    localparam logic [CW-1:0] READY_AT = CW'(SYNC_STAGES + 1);

    logic [CW-1:0] since_rst;
    logic          ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != READY_AT) begin
            since_rst <= since_rst + 1'b1;
        end
    end
    assign ready = (since_rst == READY_AT);

    // R3: either edge of a looped-back level sets its flag
    a_r3_cts_either_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && loop_en && $past(loop_en) && (loop_ctl[0] != $past(loop_ctl[0]))) |=> stat_q[0]);
    a_r3_cd_either_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && loop_en && $past(loop_en) && (loop_ctl[3] != $past(loop_ctl[3]))) |=> stat_q[3]);

    // R4: a rising ring level never sets the ring flag
    a_r4_ring_rise_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && $past(loop_en) && $rose(loop_ctl[2]) && !stat_q[2] && !stat_rd) |=> !stat_q[2]);
    a_r4_ring_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && loop_en && $past(loop_en) && $fell(loop_ctl[2])) |=> stat_q[2]);

    // R5: read with no change clears all flags
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && loop_en && $stable(loop_en) && $stable(loop_ctl)) |=> (stat_q[3:0] == 4'h0));

    // R7: flags are sticky without a read
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0])));

    // R8: interrupt gating
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_irq_en |-> !stat_irq);
    a_r8_irq_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_irq_en && (stat_q[3:0] != 4'h0)) |-> stat_irq);

    // R9: flags are clear right after reset release
    a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stat_q[3:0] == 4'h0));
endmodule

bind modem_status_reg msr_checker #(
    .SYNC_STAGES(SYNC_STAGES)
) u_msr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .loop_en    (loop_en),
    .loop_ctl   (loop_ctl),
    .stat_rd    (stat_rd),
    .stat_irq_en(stat_irq_en),
    .stat_q     (stat_q),
    .stat_irq   (stat_irq)
);

// File: tb/test_modem_status_reg.sv
`timescale 1ns/1ps
module test_modem_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_n = 4'hF;
    logic       loop_en = 1'b0;
    logic [3:0] loop_ctl = 4'h0;
    logic       stat_rd = 1'b0;
    logic       stat_irq_en = 1'b1;
    logic [7:0] stat_q;
    logic       stat_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    modem_status_reg i_modem_status_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n      (pin_n),
        .loop_en    (loop_en),
        .loop_ctl   (loop_ctl),
        .stat_rd    (stat_rd),
        .stat_irq_en(stat_irq_en),
        .stat_q     (stat_q),
        .stat_irq   (stat_irq)
    );

    // {loop_en, loop_ctl[3:0], pin_n[3:0], expected stat_q[7:0]}
    localparam logic [16:0] VEC [0:12] = '{
        {1'b0, 4'b0000, 4'b1110, 8'h11},  // R1 R3 cts asserted
        {1'b0, 4'b0000, 4'b1111, 8'h01},  // R3 cts released
        {1'b0, 4'b0000, 4'b1011, 8'h40},  // R4 ring pin low: no flag
        {1'b0, 4'b0000, 4'b1111, 8'h04},  // R4 ring pin back high
        {1'b0, 4'b0000, 4'b0101, 8'hAA},  // R3 dsr and cd
        {1'b0, 4'b0000, 4'b0001, 8'hE0},  // R4 ring low again
        {1'b0, 4'b0000, 4'b1111, 8'h0E},  // R3 R4 three releases
        {1'b1, 4'b0100, 4'b1111, 8'h40},  // R2 R4 aux1 rises
        {1'b1, 4'b0000, 4'b0000, 8'h04},  // R2 R4 aux1 falls, pins ignored
        {1'b1, 4'b1011, 4'b1111, 8'hBB},  // R2 R3 looped edges
        {1'b1, 4'b1011, 4'b0110, 8'hB0},  // R2 pins ignored
        {1'b1, 4'b1011, 4'b1111, 8'hB0},  // R2 pins ignored
        {1'b0, 4'b1011, 4'b1111, 8'h0B}   // R10 leaving loopback
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read();
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        check("R9 reset flags", stat_q, 8'h00);
        check("R9 reset irq", {7'b0, stat_irq}, 8'h00);
        rst_n = 1'b1;
        tick(6);
        check("R9 idle after reset", stat_q, 8'h00);

        for (int v = 0; v < 13; v++) begin
            loop_en  = VEC[v][16];
            loop_ctl = VEC[v][15:12];
            pin_n    = VEC[v][11:8];
            tick(4);
            check($sformatf("R1-vector %0d status", v), stat_q, VEC[v][7:0]);
            check($sformatf("R8 vector %0d irq", v), {7'b0, stat_irq},
                  {7'b0, |VEC[v][3:0]});
            do_read();
            check($sformatf("R5 vector %0d cleared", v), {4'h0, stat_q[3:0]}, 8'h00);
        end

        // R1 latency: level moves after two edges
        pin_n = 4'b1110;
        tick(1);
        check("R1 one edge", {7'b0, stat_q[4]}, 8'h00);
        tick(1);
        check("R1 two edges", {7'b0, stat_q[4]}, 8'h01);
        tick(2);
        do_read();

        // R6: change on the same edge as a read
        loop_en  = 1'b1;
        loop_ctl = 4'b0001;
        tick(3);
        do_read();
        check("R6 setup clear", {4'h0, stat_q[3:0]}, 8'h00);
        loop_ctl = 4'b0000;
        stat_rd  = 1'b1;
        tick(1);
        stat_rd  = 1'b0;
        check("R6 change kept", {7'b0, stat_q[0]}, 8'h01);

        // R8: enable gating
        stat_irq_en = 1'b0;
        #1;
        check("R8 irq disabled", {7'b0, stat_irq}, 8'h00);
        stat_irq_en = 1'b1;
        #1;
        check("R8 irq enabled", {7'b0, stat_irq}, 8'h01);

        // R7: sticky without read
        tick(5);
        check("R7 sticky", {4'h0, stat_q[3:0]}, 8'h01);

        // R9: level held through reset sets no flag
        loop_en = 1'b0;
        pin_n   = 4'b1110;
        tick(4);
        rst_n = 1'b0;
        tick(1);
        check("R9 reset clears", {4'h0, stat_q[3:0]}, 8'h00);
        rst_n = 1'b1;
        tick(8);
        check("R9 primed", stat_q, 8'h10);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule